// File: doc/BRIEF.md
# Sticky Event Interrupt Register

This block is a 16-bit management register for a PHY. It holds seven event status flags and seven matching enable bits. Each flag is set by a one-cycle pulse from the event-detection logic and stays set until software reads the register. A flag is captured whether or not its enable bit is set, so software can poll for events even when interrupts are off.

The block raises a single registered interrupt request when three things are true at once: a flag is pending, the enable bit for that flag is set, and both global permit bits are 1. The global permit bits come from a separate control register. A read of the register with the address match asserted returns the current image and clears every flag on the same clock edge. An event that arrives in the same cycle as that read is kept.

Top module: `evt_irq_reg`

## Requirements
- R1: After synchronous reset, every bit of the register image is 0 and `irq_out` is 0.
- R2: A pulse on `evt_pulse[i]` sets status bit 8+i at the next clock edge, even when enable bit i is 0. From bit 14 down to bit 8 the flags are: auto-negotiation error, page received, loopback FIFO over/underflow, crossover changed, sleep event, polarity changed and jabber. These map to `evt_pulse[6]` down to `evt_pulse[0]`.
- R3: A status flag stays set, with no further pulse, until a clearing read.
- R4: While `sel` and `rd_stb` are high, `rd_data` shows the image as it was before the clear. At the end of that cycle all status flags become 0.
- R5: If an event pulse arrives in the same cycle as a clearing read, its flag is 1 after that edge.
- R6: A write (`sel` and `wr_stb` high) loads `wr_data[6:0]` into the enable bits, which read back at bits 6:0. Enable bit i gates status bit 8+i.
- R7: A write leaves the status flags unchanged. Bits 15 and 7 always read 0.
- R8: `irq_out` is 1 after an edge if, at that edge, some flag is set together with its enable bit and `irq_permit` equals 2'b11. Otherwise it is 0.
- R9: After a clearing read, `irq_out` is 0 from the next edge on, unless an enabled event arrived during the read.
- R10: With `sel` low, strobes have no effect and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Address match for this register |
| rd_stb | input | 1 | Read strobe; clears the flags |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register image, 0 when not selected |
| evt_pulse | input | 7 | Event pulses, one per flag |
| irq_permit | input | 2 | Global interrupt permit bits |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Two things can land on the same clock edge: the clearing read and the setting of a flag by a new event pulse. The bench raises an event pulse in the cycle of the read strobe. It expects the read data to show only the older flags. After the edge it expects the new flag to be set and the interrupt to stay asserted. A write that lands while flags are pending is also checked, and the flags must come through it unchanged.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int unsigned N_EVT  = 7;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned ST_LSB = N_EVT + 1;

    typedef logic [N_EVT-1:0] evt_vec_t;

    typedef struct packed {
        logic     rsv_hi;
        evt_vec_t status;
        logic     rsv_lo;
        evt_vec_t enable;
    } reg_img_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } acc_t;

    function automatic logic [REG_W-1:0] pack_image(evt_vec_t st, evt_vec_t en);
        reg_img_t r;
        r.rsv_hi = 1'b0;
        r.status = st;
        r.rsv_lo = 1'b0;
        r.enable = en;
        return r;
    endfunction
endpackage

// File: rtl/evt_irq_flags.sv
module evt_irq_flags
    import evt_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  evt_vec_t evt,
    output evt_vec_t flags_q,
    output evt_vec_t flags_d
);
    for (genvar i = 0; i < N_EVT; i++) begin : g_flag
        // a new event wins over the clear so nothing is lost
        assign flags_d[i] = evt[i] | (flags_q[i] & ~clr);
        always_ff @(posedge clk) begin
            if (rst) flags_q[i] <= 1'b0;
            else     flags_q[i] <= flags_d[i];
        end
    end
endmodule

// File: rtl/evt_irq_enables.sv
module evt_irq_enables
    import evt_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  evt_vec_t din,
    output evt_vec_t en_q,
    output evt_vec_t en_d
);
    assign en_d = wr ? din : en_q;
    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end
endmodule

// File: rtl/evt_irq_req.sv
module evt_irq_req
    import evt_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t flags_d,
    input  evt_vec_t en_d,
    input  logic [1:0] permit,
    output logic     irq_q
);
    logic fire;
    assign fire = (|(flags_d & en_d)) & (&permit);
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= fire;
    end
endmodule

// File: rtl/evt_irq_reg.sv
module evt_irq_reg
    import evt_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [N_EVT-1:0] evt_pulse,
    input  logic [1:0]       irq_permit,
    output logic             irq_out
);
    acc_t     acc;
    evt_vec_t flags_q, flags_d, en_q, en_d;
    reg_img_t wimg;

    assign acc.rd = sel & rd_stb;
    assign acc.wr = sel & wr_stb;
    assign wimg   = wr_data;

    evt_irq_flags u_flags (
        .clk(clk), .rst(rst), .clr(acc.rd), .evt(evt_pulse),
        .flags_q(flags_q), .flags_d(flags_d)
    );

    evt_irq_enables u_en (
        .clk(clk), .rst(rst), .wr(acc.wr), .din(wimg.enable),
        .en_q(en_q), .en_d(en_d)
    );

    evt_irq_req u_req (
        .clk(clk), .rst(rst), .flags_d(flags_d), .en_d(en_d),
        .permit(irq_permit), .irq_q(irq_out)
    );

    assign rd_data = sel ? pack_image(flags_q, en_q) : '0;
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
    import evt_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sel,
    input logic             rd_stb,
    input logic             wr_stb,
    input evt_vec_t         evt,
    input evt_vec_t         flags,
    input evt_vec_t         en,
    input logic [REG_W-1:0] rd_data,
    input logic [1:0]       permit,
    input logic             irq
);
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !(sel && rd_stb) |=> ((flags & $past(flags)) == $past(flags)));

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_stb && evt == '0) |=> (flags == '0));

    p_status_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (sel && wr_stb && !rd_stb && evt == '0) |=> (flags == $past(flags)));

    p_reserved_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_data[15] == 1'b0) && (rd_data[7] == 1'b0));

    p_irq_permit_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(permit) == 2'b11));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flags & en) != '0));

    p_unsel_r10: assert property (@(posedge clk) disable iff (rst)
        !sel |-> (rd_data == '0));
endmodule

bind evt_irq_reg evt_irq_chk u_chk (
    .clk(clk), .rst(rst), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .evt(evt_pulse), .flags(flags_q), .en(en_q), .rd_data(rd_data),
    .permit(irq_permit), .irq(irq_out)
);

// File: tb/evt_irq_reg_tb.sv
module evt_irq_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        sel, rd_stb, wr_stb;
    logic [15:0] wr_data, rd_data;
    logic [6:0]  evt_pulse;
    logic [1:0]  irq_permit;
    logic        irq_out;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    evt_irq_reg dut_i (
        .clk(clk), .rst(rst), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_data(rd_data), .evt_pulse(evt_pulse),
        .irq_permit(irq_permit), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input string req, input logic [15:0] exp);
        sel = 1'b1;
        #1 chk(req, rd_data, exp);
        sel = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [15:0] exp, input logic [6:0] ev);
        sel = 1'b1; rd_stb = 1'b1; evt_pulse = ev;
        #1 chk(req, rd_data, exp);
        tick();
        sel = 1'b0; rd_stb = 1'b0; evt_pulse = '0;
    endtask

    task automatic do_write(input logic [15:0] d);
        sel = 1'b1; wr_stb = 1'b1; wr_data = d;
        tick();
        sel = 1'b0; wr_stb = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [6:0] ev);
        evt_pulse = ev;
        tick();
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        chk("R1 irq", {15'b0, irq_out}, 16'h0);
        peek("R1 image", 16'h0000);
    endtask

    task automatic t_capture();
        irq_permit = 2'b11;
        for (int i = 0; i < 7; i++) begin
            pulse(7'(1 << i));
            chk("R2 no irq when disabled", {15'b0, irq_out}, 16'h0);
            do_read("R2 flag position", 16'(1 << (8 + i)), '0);
            peek("R4 cleared", 16'h0000);
        end
    endtask

    task automatic t_sticky();
        pulse(7'h08);
        repeat (5) tick();
        peek("R3 still set", 16'h0800);
        do_read("R4 read shows flag", 16'h0800, '0);
        do_read("R4 second read empty", 16'h0000, '0);
    endtask

    task automatic t_write();
        do_write(16'hFFFF);
        peek("R6/R7 write only enables", 16'h007F);
        pulse(7'h41);
        do_write(16'h0000);
        peek("R7 flags survive write", 16'h4100);
        do_read("R4 clear", 16'h4100, '0);
        do_write(16'h002A);
        peek("R6 enable readback", 16'h002A);
    endtask

    task automatic t_irq();
        do_write(16'h007F);
        irq_permit = 2'b11;
        pulse(7'h04);
        chk("R8 irq set", {15'b0, irq_out}, 16'h1);
        irq_permit = 2'b01;
        tick();
        chk("R8 permit low", {15'b0, irq_out}, 16'h0);
        irq_permit = 2'b10;
        tick();
        chk("R8 permit other low", {15'b0, irq_out}, 16'h0);
        irq_permit = 2'b11;
        tick();
        chk("R8 permit restored", {15'b0, irq_out}, 16'h1);
        do_read("R9 read", 16'h047F, '0);
        chk("R9 irq dropped", {15'b0, irq_out}, 16'h0);
        do_write(16'h0001);
        pulse(7'h20);
        chk("R8 masked flag", {15'b0, irq_out}, 16'h0);
        peek("R2 masked flag captured", 16'h2001);
        do_write(16'h0020);
        chk("R6 late enable raises irq", {15'b0, irq_out}, 16'h1);
        do_read("R4 clear", 16'h2020, '0);
    endtask

    task automatic t_collide();
        do_write(16'h007F);
        irq_permit = 2'b11;
        pulse(7'h10);
        do_read("R5 read shows old only", 16'h107F, 7'h02);
        peek("R5 event kept", 16'h027F);
        chk("R9 irq held by collision", {15'b0, irq_out}, 16'h1);
        do_read("R5 clear", 16'h027F, '0);
        chk("R9 irq dropped", {15'b0, irq_out}, 16'h0);
    endtask

    task automatic t_unselected();
        pulse(7'h01);
        rd_stb = 1'b1; wr_stb = 1'b1; wr_data = 16'h0000;
        #1 chk("R10 rd_data zero", rd_data, 16'h0000);
        tick();
        rd_stb = 1'b0; wr_stb = 1'b0;
        peek("R10 nothing changed", 16'h017F);
        do_read("R4 clear", 16'h017F, '0);
    endtask

    initial begin
        rst = 1'b1; sel = 0; rd_stb = 0; wr_stb = 0; wr_data = '0;
        evt_pulse = '0; irq_permit = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_capture();
        t_sticky();
        t_write();
        t_irq();
        t_collide();
        t_unselected();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule